// File: doc/BRIEF.md
# Asymmetric Erase-Block Decoder with Boot Lock

This block sits between a flash command interpreter and its program/erase engine. For each program or erase request it finds which of eleven unequal erase blocks the address falls in. The blocks are one 16KB boot block, two 8KB parameter blocks, one 96KB main block and seven 128KB main blocks. The block reports that block's index and its first and last word address, which an erase walk uses. It then decides whether the operation may start.

The boot block can sit at the bottom or at the top of the word space. A parameter picks which. The top build is the bottom build mirrored, so the same block index always means the same kind of block. Index 0 is the boot block. Indices 1 and 2 are the parameter blocks, with 1 the one next to the boot block. Index 3 is the 96KB main block. Indices 4 and up are the 128KB main blocks, counted outward from the boot block.

Every block needs a valid programming supply. The boot block also needs either the write-protect input high or the reset pin at its unlock super-voltage. Both voltage conditions arrive as digital inputs. The boot condition must also hold for the whole operation. If it drops before the engine reports completion, the operation is aborted and the abort is reported as a program or an erase failure, depending on the operation type.

The controller has four states:
- IDLE accepts a command. Going from IDLE to RUN grants a non-boot operation. Going from IDLE to RUN_BOOT grants a boot operation. A refused command stays in IDLE.
- RUN waits for `op_done` and then returns to IDLE.
- RUN_BOOT also waits for `op_done` and returns to IDLE. It moves to ABORT instead if the unlock is lost.
- ABORT lasts one cycle and then returns to IDLE.

Top module: `flash_sector_guard`

## Requirements
- R1: Bottom build (TOP_BOOT=0), by word address:
  - 00000h–01FFFh is index 0.
  - 02000h–02FFFh is index 1.
  - 03000h–03FFFh is index 2.
  - 04000h–0FFFFh is index 3.
  - Each 10000h-word span from 10000h upward is index 3 + (address >> 16).
- R2: Top build (TOP_BOOT=1), by word address:
  - 7E000h–7FFFFh is index 0.
  - 7D000h–7DFFFh is index 1.
  - 7C000h–7CFFFh is index 2.
  - 70000h–7BFFFh is index 3.
  - Each 10000h-word span below 70000h is index 4 + (6 − (address >> 16)).
- R3: `blk_base` and `blk_end` give the lowest and highest word address of the decoded block.
- R4: Address form depends on `byte_mode`. With `byte_mode` high the word address is `addr_in[19:1]` and bit 0 is dropped. With it low the word address is `addr_in[18:0]`. Both forms of one location decode to the same block.
- R5: A command with `vpp_ok` low is refused with `err_code` 1 (supply low), whatever block it targets.
- R6: A boot-block command with a valid supply is refused with `err_code` 2 (boot locked) unless `wp_high` or `rp_unlock` is high.
- R7: A command to any other block is granted whenever `vpp_ok` is high, whatever `wp_high` and `rp_unlock` are.
- R8: Accepted commands are answered one cycle after the cycle they are sampled in.
  - A grant shows `grant` high for that one cycle, with `err_code` 0. `busy` then stays high until the cycle after `op_done` is sampled.
  - A refusal shows `fail` high for that one cycle and leaves `busy` low.
- R9: During a boot-block operation, a cycle sampled with both `wp_high` and `rp_unlock` low aborts the operation. One cycle later `fail` pulses, with `err_code` 3 for a program or 4 for an erase (`cmd_is_erase` high). `busy` falls the cycle after that.
- R10: During a non-boot operation, `wp_high` and `rp_unlock` have no effect. The operation runs until `op_done`.
- R11: While `busy` is high, `cmd_valid` is ignored: no grant or fail pulse appears, and the block outputs keep their values.
- R12: After reset, `grant`, `fail` and `busy` are low, `err_code` is 0 and `blk_idx` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Program/erase request, sampled in IDLE |
| cmd_is_erase | input | 1 | 1 = erase, 0 = program |
| byte_mode | input | 1 | 1 = addr_in carries a byte address |
| addr_in | input | ADDR_W+1 | Request address (byte or word form) |
| wp_high | input | 1 | Write-protect pin high |
| rp_unlock | input | 1 | Reset pin at unlock super-voltage |
| vpp_ok | input | 1 | Programming supply valid |
| op_done | input | 1 | Engine reports operation complete |
| grant | output | 1 | One-cycle start permission |
| fail | output | 1 | One-cycle refusal or abort |
| err_code | output | 3 | 0 none, 1 supply low, 2 boot locked, 3 program aborted, 4 erase aborted |
| busy | output | 1 | Operation in progress |
| blk_idx | output | IDX_W | Decoded block index |
| blk_base | output | ADDR_W | First word address of the block |
| blk_end | output | ADDR_W | Last word address of the block |

## Verification
The checker enforces several rules on every cycle:
- Grant and fail never coincide, and a grant comes with `busy` and a clean error code.
- A boot-block grant is always preceded by a present unlock and supply.
- An abort code always follows a cycle in which the unlock was absent during an operation.
- The block outputs hold still while an operation runs, and every reported block is 4K-word aligned with its base below its end.

Only the bench's scenarios can confirm that each address lands in the correct block with the correct bounds in both builds and both bus widths. They also show which refusal code each supply and unlock combination produces, and that losing the unlock aborts a boot operation but leaves other blocks untouched.

// File: rtl/fsg_pkg.sv
package fsg_pkg;

    typedef enum logic [1:0] {
        ST_IDLE     = 2'd0,
        ST_RUN      = 2'd1,
        ST_RUN_BOOT = 2'd2,
        ST_ABORT    = 2'd3
    } fsg_state_e;

    typedef enum logic [2:0] {
        ERR_NONE        = 3'd0,
        ERR_SUPPLY_LOW  = 3'd1,
        ERR_BOOT_LOCKED = 3'd2,
        ERR_PROG_ABORT  = 3'd3,
        ERR_ERASE_ABORT = 3'd4
    } fsg_err_e;

endpackage

// File: rtl/fsg_addr_norm.sv
// Strips the byte lane bit and folds a top-boot layout onto the bottom-boot one.
module fsg_addr_norm #(
    parameter int ADDR_W   = 19,
    parameter bit TOP_BOOT = 1'b0
) (
    input  logic              byte_mode,
    input  logic [ADDR_W:0]   addr_in,
    output logic [ADDR_W-1:0] norm_addr
);
    logic [ADDR_W-1:0] word_addr;

    assign word_addr = byte_mode ? addr_in[ADDR_W:1] : addr_in[ADDR_W-1:0];

    generate
        if (TOP_BOOT) begin : g_mirror
            assign norm_addr = ~word_addr;
        end else begin : g_direct
            assign norm_addr = word_addr;
        end
    endgenerate
endmodule

// File: rtl/fsg_block_map.sv
// Decodes a normalised (boot-at-zero) address into block index and real bounds.
module fsg_block_map #(
    parameter int ADDR_W   = 19,
    parameter bit TOP_BOOT = 1'b0,
    parameter int IDX_W    = 4
) (
    input  logic [ADDR_W-1:0] norm_addr,
    output logic [IDX_W-1:0]  idx,
    output logic              is_boot,
    output logic [ADDR_W-1:0] base,
    output logic [ADDR_W-1:0] last
);
    localparam int BIG_SH  = 16;
    localparam int UNIT_SH = 12;
    localparam int HI_W    = ADDR_W - BIG_SH;

    logic [HI_W-1:0]   hi;
    logic [3:0]        unit;
    logic [ADDR_W-1:0] nbase, nlast;

    assign hi   = norm_addr[ADDR_W-1:BIG_SH];
    assign unit = norm_addr[BIG_SH-1:UNIT_SH];

    always_comb begin
        if (hi != '0) begin
            idx   = IDX_W'(hi) + IDX_W'(3);
            nbase = {hi, {BIG_SH{1'b0}}};
            nlast = {hi, {BIG_SH{1'b1}}};
        end else if (unit < 4'd2) begin
            idx   = IDX_W'(0);
            nbase = ADDR_W'(20'h00000);
            nlast = ADDR_W'(20'h01FFF);
        end else if (unit == 4'd2) begin
            idx   = IDX_W'(1);
            nbase = ADDR_W'(20'h02000);
            nlast = ADDR_W'(20'h02FFF);
        end else if (unit == 4'd3) begin
            idx   = IDX_W'(2);
            nbase = ADDR_W'(20'h03000);
            nlast = ADDR_W'(20'h03FFF);
        end else begin
            idx   = IDX_W'(3);
            nbase = ADDR_W'(20'h04000);
            nlast = ADDR_W'(20'h0FFFF);
        end
    end

    assign is_boot = (idx == '0);

    generate
        if (TOP_BOOT) begin : g_unfold
            assign base = ~nlast;
            assign last = ~nbase;
        end else begin : g_plain
            assign base = nbase;
            assign last = nlast;
        end
    endgenerate
endmodule

// File: rtl/fsg_policy.sv
// Permission decision for a freshly sampled command.
module fsg_policy (
    input  logic           is_boot,
    input  logic           wp_high,
    input  logic           rp_unlock,
    input  logic           vpp_ok,
    output logic           permit,
    output fsg_pkg::fsg_err_e why
);
    import fsg_pkg::*;

    always_comb begin
        if (!vpp_ok) begin
            why = ERR_SUPPLY_LOW;
        end else if (is_boot && !(wp_high || rp_unlock)) begin
            why = ERR_BOOT_LOCKED;
        end else begin
            why = ERR_NONE;
        end
    end

    assign permit = (why == ERR_NONE);
endmodule

// File: rtl/flash_sector_guard.sv
module flash_sector_guard #(
    parameter int ADDR_W   = 19,
    parameter bit TOP_BOOT = 1'b0,
    parameter int NUM_BLK  = 4 + (2 ** (ADDR_W - 16)) - 1,
    parameter int IDX_W    = $clog2(NUM_BLK)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_valid,
    input  logic              cmd_is_erase,
    input  logic              byte_mode,
    input  logic [ADDR_W:0]   addr_in,
    input  logic              wp_high,
    input  logic              rp_unlock,
    input  logic              vpp_ok,
    input  logic              op_done,
    output logic              grant,
    output logic              fail,
    output logic [2:0]        err_code,
    output logic              busy,
    output logic [IDX_W-1:0]  blk_idx,
    output logic [ADDR_W-1:0] blk_base,
    output logic [ADDR_W-1:0] blk_end
);
    import fsg_pkg::*;

    fsg_state_e        state_q, state_d;
    logic [ADDR_W-1:0] norm_addr;
    logic [IDX_W-1:0]  map_idx;
    logic              map_boot;
    logic [ADDR_W-1:0] map_base, map_last;
    logic              permit;
    fsg_err_e          why;
    fsg_err_e          err_q;
    logic              op_erase_q;
    logic              unlock;

    assign unlock = wp_high || rp_unlock;

    fsg_addr_norm #(.ADDR_W(ADDR_W), .TOP_BOOT(TOP_BOOT)) u_norm (
        .byte_mode (byte_mode),
        .addr_in   (addr_in),
        .norm_addr (norm_addr)
    );

    fsg_block_map #(.ADDR_W(ADDR_W), .TOP_BOOT(TOP_BOOT), .IDX_W(IDX_W)) u_map (
        .norm_addr (norm_addr),
        .idx       (map_idx),
        .is_boot   (map_boot),
        .base      (map_base),
        .last      (map_last)
    );

    fsg_policy u_pol (
        .is_boot   (map_boot),
        .wp_high   (wp_high),
        .rp_unlock (rp_unlock),
        .vpp_ok    (vpp_ok),
        .permit    (permit),
        .why       (why)
    );

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (cmd_valid && permit) begin
                    state_d = map_boot ? ST_RUN_BOOT : ST_RUN;
                end
            end
            ST_RUN: begin
                if (op_done) state_d = ST_IDLE;
            end
            ST_RUN_BOOT: begin
                if (!unlock)      state_d = ST_ABORT;
                else if (op_done) state_d = ST_IDLE;
            end
            ST_ABORT: state_d = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // registered outputs
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            grant      <= 1'b0;
            fail       <= 1'b0;
            err_q      <= ERR_NONE;
            op_erase_q <= 1'b0;
            blk_idx    <= '0;
            blk_base   <= '0;
            blk_end    <= '0;
        end else begin
            grant <= 1'b0;
            fail  <= 1'b0;
            unique case (state_q)
                ST_IDLE: begin
                    if (cmd_valid) begin
                        blk_idx    <= map_idx;
                        blk_base   <= map_base;
                        blk_end    <= map_last;
                        op_erase_q <= cmd_is_erase;
                        err_q      <= why;
                        grant      <= permit;
                        fail       <= !permit;
                    end
                end
                ST_RUN_BOOT: begin
                    if (!unlock) begin
                        fail  <= 1'b1;
                        err_q <= op_erase_q ? ERR_ERASE_ABORT : ERR_PROG_ABORT;
                    end
                end
                ST_RUN, ST_ABORT: begin
                end
            endcase
        end
    end

    assign err_code = err_q;
    assign busy     = (state_q != ST_IDLE);
endmodule

// File: rtl/fsg_checker.sv
module fsg_checker #(
    parameter int ADDR_W = 19,
    parameter int IDX_W  = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic              wp_high,
    input logic              rp_unlock,
    input logic              vpp_ok,
    input logic              grant,
    input logic              fail,
    input logic [2:0]        err_code,
    input logic              busy,
    input logic [IDX_W-1:0]  blk_idx,
    input logic [ADDR_W-1:0] blk_base,
    input logic [ADDR_W-1:0] blk_end
);
    a_r8_grant_fail_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        !(grant && fail));

    a_r8_grant_starts_busy: assert property (@(posedge clk) disable iff (!rst_n)
        grant |-> (busy && err_code == 3'd0));

    a_r6_boot_grant_unlocked: assert property (@(posedge clk) disable iff (!rst_n)
        (grant && blk_idx == '0) |-> $past(wp_high || rp_unlock));

    a_r5_grant_needs_supply: assert property (@(posedge clk) disable iff (!rst_n)
        grant |-> $past(vpp_ok));

    a_r9_abort_cause: assert property (@(posedge clk) disable iff (!rst_n)
        (fail && (err_code == 3'd3 || err_code == 3'd4)) |->
            ($past(busy) && !$past(wp_high || rp_unlock)));

    a_r11_hold_while_busy: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !grant) |-> ($stable(blk_idx) && $stable(blk_base) && $stable(blk_end)));

    a_r3_bounds_shape: assert property (@(posedge clk) disable iff (!rst_n)
        grant |-> (blk_base <= blk_end && blk_base[11:0] == '0 && blk_end[11:0] == '1));
endmodule

bind flash_sector_guard fsg_checker #(.ADDR_W(ADDR_W), .IDX_W(IDX_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .wp_high   (wp_high),
    .rp_unlock (rp_unlock),
    .vpp_ok    (vpp_ok),
    .grant     (grant),
    .fail      (fail),
    .err_code  (err_code),
    .busy      (busy),
    .blk_idx   (blk_idx),
    .blk_base  (blk_base),
    .blk_end   (blk_end)
);

// File: tb/sim_flash_sector_guard.sv
`timescale 1ns/1ps
module sim_flash_sector_guard;
    localparam int AW = 19;
    localparam int IW = 4;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          cmd_valid = 1'b0, cmd_is_erase = 1'b0, byte_mode = 1'b0;
    logic [AW:0]   addr_in = '0;
    logic          wp_high = 1'b0, rp_unlock = 1'b0, vpp_ok = 1'b0, op_done = 1'b0;

    logic          g0, f0, b0, g1, f1, b1;
    logic [2:0]    e0, e1;
    logic [IW-1:0] i0, i1;
    logic [AW-1:0] s0, t0, s1, t1;

    int vectors = 0;
    int misses  = 0;

    always #4 clk = ~clk;

    flash_sector_guard #(.ADDR_W(AW), .TOP_BOOT(1'b0)) u0 (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_is_erase(cmd_is_erase),
        .byte_mode(byte_mode), .addr_in(addr_in), .wp_high(wp_high), .rp_unlock(rp_unlock),
        .vpp_ok(vpp_ok), .op_done(op_done), .grant(g0), .fail(f0), .err_code(e0),
        .busy(b0), .blk_idx(i0), .blk_base(s0), .blk_end(t0));

    flash_sector_guard #(.ADDR_W(AW), .TOP_BOOT(1'b1)) u1 (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_is_erase(cmd_is_erase),
        .byte_mode(byte_mode), .addr_in(addr_in), .wp_high(wp_high), .rp_unlock(rp_unlock),
        .vpp_ok(vpp_ok), .op_done(op_done), .grant(g1), .fail(f1), .err_code(e1),
        .busy(b1), .blk_idx(i1), .blk_base(s1), .blk_end(t1));

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        vectors++;
        if (!ok) begin
            misses++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic chk_eq(input string req, input string what, input longint act, input longint exp);
        chk(act == exp, req, what, act, exp);
    endtask

    // expected map, bottom build
    function automatic void exp_bot(input int w, output int idx, output int lo, output int hi);
        if (w < 'h2000)       begin idx = 0; lo = 'h0;    hi = 'h1FFF; end
        else if (w < 'h3000)  begin idx = 1; lo = 'h2000; hi = 'h2FFF; end
        else if (w < 'h4000)  begin idx = 2; lo = 'h3000; hi = 'h3FFF; end
        else if (w < 'h10000) begin idx = 3; lo = 'h4000; hi = 'hFFFF; end
        else begin idx = 3 + (w >> 16); lo = (w >> 16) << 16; hi = lo + 'hFFFF; end
    endfunction

    // expected map, top build
    function automatic void exp_top(input int w, output int idx, output int lo, output int hi);
        if (w >= 'h7E000)      begin idx = 0; lo = 'h7E000; hi = 'h7FFFF; end
        else if (w >= 'h7D000) begin idx = 1; lo = 'h7D000; hi = 'h7DFFF; end
        else if (w >= 'h7C000) begin idx = 2; lo = 'h7C000; hi = 'h7CFFF; end
        else if (w >= 'h70000) begin idx = 3; lo = 'h70000; hi = 'h7BFFF; end
        else begin idx = 4 + (6 - (w >> 16)); lo = (w >> 16) << 16; hi = lo + 'hFFFF; end
    endfunction

    // drive a command for one cycle; returns at the negedge after the sampling edge
    task automatic issue(input int w, input bit bm, input bit lane, input bit er);
        byte_mode    = bm;
        addr_in      = bm ? {w[AW-1:0], lane} : {1'b0, w[AW-1:0]};
        cmd_is_erase = er;
        cmd_valid    = 1'b1;
        @(negedge clk);
        cmd_valid    = 1'b0;
    endtask

    task automatic finish_op();
        op_done = 1'b1;
        @(negedge clk);
        op_done = 1'b0;
    endtask

    task automatic report();
        $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
        $finish;
    endtask

    initial begin
        #(8 * 150000);
        misses++;
        $display("FAIL watchdog: actual hung expected finish");
        report();
    end

    initial begin
        int ei, el, eh;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R12 reset state
        chk_eq("R12", "grant", g0 | g1, 0);
        chk_eq("R12", "fail", f0 | f1, 0);
        chk_eq("R12", "busy", b0 | b1, 0);
        chk_eq("R12", "err", e0 | e1, 0);
        chk_eq("R12", "idx", i0 | i1, 0);

        // R1 R2 R3 R4: sweep every 4K unit, first and last word, alternating bus width
        vpp_ok = 1'b1; wp_high = 1'b1;
        for (int u = 0; u < 128; u++) begin
            for (int k = 0; k < 2; k++) begin
                int w = u * 4096 + (k ? 'hFFF : 0);
                bit bm = u[0];
                issue(w, bm, k[0], 1'b0);
                exp_bot(w, ei, el, eh);
                chk_eq(bm ? "R4" : "R1", "bottom idx", i0, ei);
                chk_eq("R3", "bottom base", s0, el);
                chk_eq("R3", "bottom end", t0, eh);
                exp_top(w, ei, el, eh);
                chk_eq(bm ? "R4" : "R2", "top idx", i1, ei);
                chk_eq("R3", "top base", s1, el);
                chk_eq("R3", "top end", t1, eh);
                chk_eq("R8", "grant both", {g0, g1}, 2'b11);
                finish_op();
                chk_eq("R8", "busy cleared", b0 | b1, 0);
            end
        end

        // R5 R6 R7: all supply/unlock combinations; word 0 is boot in u0, main in u1
        for (int c = 0; c < 8; c++) begin
            for (int a = 0; a < 2; a++) begin
                int w = a ? 'h7FFFF : 0;
                bit boot_bot = (a == 0);
                int eb, en;
                vpp_ok = c[0]; wp_high = c[1]; rp_unlock = c[2];
                issue(w, 1'b0, 1'b0, c[0]);
                eb = !c[0] ? 1 : ((c[1] || c[2]) ? 0 : 2);
                en = !c[0] ? 1 : 0;
                chk_eq(c[0] ? "R6" : "R5", "boot-side err", boot_bot ? e0 : e1, eb);
                chk_eq("R6", "boot-side grant", boot_bot ? g0 : g1, eb == 0);
                chk_eq("R8", "boot-side fail", boot_bot ? f0 : f1, eb != 0);
                chk_eq(c[0] ? "R7" : "R5", "main-side err", boot_bot ? e1 : e0, en);
                chk_eq("R7", "main-side grant", boot_bot ? g1 : g0, en == 0);
                if (eb != 0) chk_eq("R8", "refused not busy", boot_bot ? b0 : b1, 0);
                finish_op();
            end
        end

        // R9 R10: erase with write-protect held, then lost
        vpp_ok = 1'b1; wp_high = 1'b1; rp_unlock = 1'b0;
        issue(0, 1'b0, 1'b0, 1'b1);
        wp_high = 1'b0;
        @(negedge clk);
        chk_eq("R9", "erase abort fail", f0, 1);
        chk_eq("R9", "erase abort code", e0, 4);
        chk_eq("R10", "main op no fail", f1, 0);
        @(negedge clk);
        chk_eq("R9", "busy released", b0, 0);
        chk_eq("R10", "main op still busy", b1, 1);
        chk_eq("R10", "main op err clean", e1, 0);
        finish_op();
        chk_eq("R10", "main op done", b1, 0);

        // R9: program with reset-pin unlock held, then lost
        rp_unlock = 1'b1;
        issue(0, 1'b0, 1'b0, 1'b0);
        rp_unlock = 1'b0;
        @(negedge clk);
        chk_eq("R9", "program abort fail", f0, 1);
        chk_eq("R9", "program abort code", e0, 3);
        @(negedge clk);
        finish_op();

        // R9: one of two unlocks remaining keeps the boot operation alive
        wp_high = 1'b1; rp_unlock = 1'b1;
        issue(0, 1'b0, 1'b0, 1'b1);
        wp_high = 1'b0;
        repeat (2) @(negedge clk);
        chk_eq("R9", "no abort while held", {f0, b0}, 2'b01);
        finish_op();
        chk_eq("R9", "clean finish", {b0, e0}, 0);

        // R11: command during an operation is ignored
        wp_high = 1'b1;
        issue(0, 1'b0, 1'b0, 1'b0);
        issue('h7FFFF, 1'b0, 1'b0, 1'b1);
        chk_eq("R11", "no grant", g0 | g1, 0);
        chk_eq("R11", "no fail", f0 | f1, 0);
        chk_eq("R11", "bottom idx kept", i0, 0);
        chk_eq("R11", "top idx kept", i1, 10);
        chk_eq("R11", "bottom base kept", s0, 0);
        finish_op();
        chk_eq("R11", "idle after", b0 | b1, 0);

        report();
    end
endmodule